// File: doc/BRIEF.md
# Triggered ADC Conversion Controller

This block runs single conversions on an external 12-bit successive-approximation converter. It is mapped onto a byte-wide register bus. Software writes a control byte, which selects the channel, the single-ended or differential input and the range. It also writes a sub-multiplexer byte of four tag bits and three gain bits, and an option byte that turns the start sources on. A conversion begins on a software write, on a rising edge of an external start pin, or on a terminal-count pulse from a pacer timer.

While a conversion runs, the controller is busy and ignores any further start request. When the converter reports completion, the controller stores the 12-bit sample. The four tag bits that were present when that conversion began are stored with it in the upper nibble of a 16-bit result. If interrupts are enabled, the controller then raises an interrupt request, which stays up until software reads the status byte.

Top module: `adcc_top`

## Requirements
- R1: After reset the control, sub-multiplexer, option and result registers are zero, `irq` and `adc_start` are low, and the status byte (address 4) reads 0x80.
- R2: A write to address 2 stores the control byte: channel in bits 7..4, differential select in bit 3 (1 = differential), range code in bits 2..0. A read of address 2 returns that byte, and `adc_range` and `adc_diff` carry its fields.
- R3: In single-ended mode `adc_chan` equals the channel field. In differential mode `adc_chan` has its top bit forced to 0, while the readback keeps the written value.
- R4: A write to address 3 stores the sub-multiplexer byte: tag bits 7..4 drive `submux_sel` and gain bits 2..0 drive `submux_gain`. Bit 3 is not stored and reads as 0.
- R5: A write of any value to address 0 while idle produces exactly one `adc_start` pulse of one cycle, in the cycle after the write.
- R6: Status bit 7 reads 0 from the `adc_start` pulse until the cycle after `adc_done`, and reads 1 when idle.
- R7: The result reads as bits 7..0 at address 0 and bits 15..8 at address 1. Bits 11..0 hold the sample and bits 15..12 hold the tag bits captured when that conversion started; later tag writes do not change the result.
- R8: Status bit 0 follows the external start pin two clocks late, whether or not external starts are enabled.
- R9: With option bit 7 set, a rising edge of the external start pin starts one conversion; holding the pin high starts no more.
- R10: With option bit 0 set, a one-cycle `pacer_tc` pulse starts one conversion. With the bit clear, the pulse starts nothing.
- R11: With option bit 2 set, each `adc_done` ending a conversion raises `irq`, and `irq` falls after a read of address 4. With the bit clear, `irq` stays low.
- R12: A start request from any source that arrives while a conversion is busy is ignored.
- R13: Option bits 6..3 and 1 are stored but enable no start source and no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 4 clears the interrupt) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational on `bus_addr`) |
| ext_start_pin | input | 1 | Asynchronous external start pin |
| pacer_tc | input | 1 | Terminal-count pulse from the pacer timer |
| adc_start | output | 1 | One-cycle start pulse to the converter |
| adc_done | input | 1 | Completion pulse from the converter |
| adc_data | input | 12 | Sample from the converter, valid with `adc_done` |
| adc_chan | output | 4 | Multiplexer channel |
| adc_diff | output | 1 | Differential select |
| adc_range | output | 3 | Range code |
| submux_sel | output | 4 | Sub-multiplexer select / tag bits |
| submux_gain | output | 3 | Sub-multiplexer gain bits |
| irq | output | 1 | End-of-conversion interrupt request |

## Verification
On every cycle, the embedded assertions check the following. No `adc_start` may follow a busy cycle. Each start pulse lasts one cycle and sets busy. The captured tag holds steady through a conversion. The interrupt rises only with its enable set and drops after a status read. A synchronised pin rise lasts one cycle, and the control byte changes only on a write to its address. Other behaviour shows only in the bench's scenarios, which compare against the cycle model: which start sources each option pattern admits, the tag that a conversion keeps after a later tag write, the two-clock lag of the pin status, and the effect of a level held high.

// File: rtl/adcc_pkg.sv
// Package adcc_pkg
// Shared register addresses, bit positions and field layouts for the
// triggered conversion controller. Assumes a byte-wide bus with a
// three-bit address.
package adcc_pkg;
    localparam int BUS_AW = 3;
    localparam int BUS_DW = 8;

    localparam logic [BUS_AW-1:0] A_DATA_LO = 3'd0;
    localparam logic [BUS_AW-1:0] A_DATA_HI = 3'd1;
    localparam logic [BUS_AW-1:0] A_CTRL    = 3'd2;
    localparam logic [BUS_AW-1:0] A_SUBMUX  = 3'd3;
    localparam logic [BUS_AW-1:0] A_OPTSTAT = 3'd4;

    localparam int OPT_TC_EN  = 0;
    localparam int OPT_IRQ_EN = 2;
    localparam int OPT_EXT_EN = 7;

    localparam int ST_IDLE = 7;
    localparam int ST_PIN  = 0;

    typedef struct packed {
        logic [3:0] chan;
        logic       diff;
        logic [2:0] range;
    } ctrl_t;

    typedef struct packed {
        logic [3:0] sel;
        logic       spare;
        logic [2:0] gain;
    } submux_t;
endpackage

// File: rtl/adcc_regs.sv
// Module adcc_regs
// Holds the writable registers: control, sub-multiplexer and option.
// Decodes the software start strobe. Assumes writes are one-cycle
// strobes. The spare sub-multiplexer bit is never stored.
module adcc_regs
    import adcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output ctrl_t             ctrl_q,
    output submux_t           submux_q,
    output logic [BUS_DW-1:0] option_q,
    output logic              sw_start
);
    logic wr_ctrl, wr_sub, wr_opt;

    // Address decode for the write strobes.
    always_comb begin
        wr_ctrl  = bus_wr && (bus_addr == A_CTRL);
        wr_sub   = bus_wr && (bus_addr == A_SUBMUX);
        wr_opt   = bus_wr && (bus_addr == A_OPTSTAT);
        sw_start = bus_wr && (bus_addr == A_DATA_LO);
    end

    // Control byte storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= ctrl_t'(bus_wdata);
    end

    // Sub-multiplexer byte storage; the spare bit is held at zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            submux_q <= '0;
        end else if (wr_sub) begin
            submux_q.sel   <= bus_wdata[7:4];
            submux_q.spare <= 1'b0;
            submux_q.gain  <= bus_wdata[2:0];
        end
    end

    // Option byte storage; all bits kept, only some are used elsewhere.
    always_ff @(posedge clk) begin
        if (!rst_n)      option_q <= '0;
        else if (wr_opt) option_q <= bus_wdata;
    end

    // R2: control byte changes only on a write to its address
    a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == A_CTRL) |=> $stable(ctrl_q));
    // R4: spare bit never reads back set
    a_r4_spare_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sub |=> !submux_q.spare);
endmodule

// File: rtl/adcc_trigger.sv
// Module adcc_trigger
// Synchronises the external start pin and finds its rising edge.
// Merges the three start sources, each behind its own enable.
// Assumes pacer_tc is already synchronous to clk.
module adcc_trigger #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_pin,
    input  logic ext_en,
    input  logic pacer_tc,
    input  logic tc_en,
    input  logic sw_start,
    output logic ext_level,
    output logic start_req
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_rise;

    // Synchroniser chain for the asynchronous pin.
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= ext_pin;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[s] <= 1'b0;
                else        sync_q[s] <= sync_q[s-1];
            end
        end
    end

    // Previous synchronised level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    // Edge detect and merging of the gated sources.
    always_comb begin
        ext_level = sync_q[LAST];
        ext_rise  = sync_q[LAST] && !prev_q;
        start_req = sw_start || (ext_en && ext_rise) || (tc_en && pacer_tc);
    end

    // R9: a detected rise lasts exactly one cycle
    a_r9_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
        ext_rise |=> !ext_rise);
endmodule

// File: rtl/adcc_seq.sv
// Module adcc_seq
// Conversion sequencer. It issues a one-cycle start pulse and tracks busy.
// It captures the tag at start, loads the result on done and manages
// the interrupt. Assumes adc_done arrives as a one-cycle pulse.
module adcc_seq #(
    parameter int RES_W = 12,
    parameter int TAG_W = 4,
    localparam int RSLT_W = RES_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_req,
    input  logic [TAG_W-1:0]  tag_in,
    input  logic              irq_en,
    input  logic              status_rd,
    input  logic              adc_done,
    input  logic [RES_W-1:0]  adc_data,
    output logic              adc_start,
    output logic              busy,
    output logic [RSLT_W-1:0] result,
    output logic              irq
);
    logic             go, finish;
    logic [TAG_W-1:0] tag_q;

    // Accept starts only when idle; accept done only when busy.
    always_comb begin
        go     = start_req && !busy;
        finish = busy && adc_done;
    end

    // Busy flag and start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            adc_start <= 1'b0;
        end else begin
            adc_start <= go;
            if (go)          busy <= 1'b1;
            else if (finish) busy <= 1'b0;
        end
    end

    // Tag captured at the moment a conversion starts.
    always_ff @(posedge clk) begin
        if (!rst_n)  tag_q <= '0;
        else if (go) tag_q <= tag_in;
    end

    // Result register loaded on completion.
    always_ff @(posedge clk) begin
        if (!rst_n)      result <= '0;
        else if (finish) result <= {tag_q, adc_data};
    end

    // Interrupt: set on an enabled completion (wins), cleared by a status read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 irq <= 1'b0;
        else if (finish && irq_en)  irq <= 1'b1;
        else if (status_rd)         irq <= 1'b0;
    end

    // R12: no start may follow a busy cycle
    a_r12_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !adc_start);
    // R5: start pulse is one cycle wide
    a_r5_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    // R6: a start pulse coincides with busy
    a_r6_busy_with_start: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> busy);
    // R7: tag is held while a conversion runs
    a_r7_tag_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(tag_q));
    // R11: interrupt rises only when enabled
    a_r11_irq_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(irq_en));
    // R11: a status read without a competing completion clears the interrupt
    a_r11_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_rd && !finish) |=> !irq);
endmodule

// File: rtl/adcc_top.sv
// Module adcc_top
// Triggered conversion controller top. It joins the register file,
// the trigger logic and the sequencer, and forms the read mux and the
// channel output. Assumes a 16-bit result read as two bytes.
module adcc_top
    import adcc_pkg::*;
#(
    parameter int RES_W       = 12,
    parameter int TAG_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_rd,
    input  logic [2:0]   bus_addr,
    input  logic [7:0]   bus_wdata,
    output logic [7:0]   bus_rdata,
    input  logic         ext_start_pin,
    input  logic         pacer_tc,
    output logic         adc_start,
    input  logic         adc_done,
    input  logic [11:0]  adc_data,
    output logic [3:0]   adc_chan,
    output logic         adc_diff,
    output logic [2:0]   adc_range,
    output logic [3:0]   submux_sel,
    output logic [2:0]   submux_gain,
    output logic         irq
);
    localparam int RSLT_W = RES_W + TAG_W;

    ctrl_t             ctrl_q;
    submux_t           submux_q;
    logic [7:0]        option_q;
    logic              sw_start, ext_level, start_req;
    logic              busy, status_rd;
    logic [RSLT_W-1:0] result;
    logic [7:0]        status;

    adcc_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ctrl_q    (ctrl_q),
        .submux_q  (submux_q),
        .option_q  (option_q),
        .sw_start  (sw_start)
    );

    adcc_trigger #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .ext_pin   (ext_start_pin),
        .ext_en    (option_q[OPT_EXT_EN]),
        .pacer_tc  (pacer_tc),
        .tc_en     (option_q[OPT_TC_EN]),
        .sw_start  (sw_start),
        .ext_level (ext_level),
        .start_req (start_req)
    );

    adcc_seq #(.RES_W(RES_W), .TAG_W(TAG_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_req (start_req),
        .tag_in    (submux_q.sel),
        .irq_en    (option_q[OPT_IRQ_EN]),
        .status_rd (status_rd),
        .adc_done  (adc_done),
        .adc_data  (adc_data),
        .adc_start (adc_start),
        .busy      (busy),
        .result    (result),
        .irq       (irq)
    );

    // Status byte assembly and the status-read strobe.
    always_comb begin
        status          = '0;
        status[ST_IDLE] = !busy;
        status[ST_PIN]  = ext_level;
        status_rd       = bus_rd && (bus_addr == A_OPTSTAT);
    end

    // Read data multiplexer.
    always_comb begin
        case (bus_addr)
            A_DATA_LO: bus_rdata = result[7:0];
            A_DATA_HI: bus_rdata = result[15:8];
            A_CTRL:    bus_rdata = ctrl_q;
            A_SUBMUX:  bus_rdata = submux_q;
            A_OPTSTAT: bus_rdata = status;
            default:   bus_rdata = '0;
        endcase
    end

    // Outputs to the converter, channel top bit masked in differential mode.
    always_comb begin
        adc_chan    = ctrl_q.diff ? {1'b0, ctrl_q.chan[2:0]} : ctrl_q.chan;
        adc_diff    = ctrl_q.diff;
        adc_range   = ctrl_q.range;
        submux_sel  = submux_q.sel;
        submux_gain = submux_q.gain;
    end
endmodule

// File: tb/adcc_top_bench.sv
// Bench for adcc_top: a behavioural cycle model, checked every clock,
// plus directed scenarios.
module adcc_top_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [2:0]  bus_addr = 0;
    logic [7:0]  bus_wdata = 0;
    logic [7:0]  bus_rdata;
    logic        ext_start_pin = 0, pacer_tc = 0, adc_done = 0;
    logic [11:0] adc_data = 0;
    logic        adc_start, adc_diff, irq;
    logic [3:0]  adc_chan, submux_sel;
    logic [2:0]  adc_range, submux_gain;

    int checks = 0, fails = 0, start_cnt = 0;

    adcc_top u_adcc_top (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Behavioural reference model
    bit [7:0]  m_ctrl, m_sub, m_opt;
    bit        m_busy, m_irq, m_start, m_edge;
    bit [1:0]  m_s;
    bit [3:0]  m_tag;
    bit [15:0] m_result;

    always @(posedge clk) begin
        bit rise, req, go, fin;
        if (!rst_n) begin
            m_ctrl = 0; m_sub = 0; m_opt = 0; m_busy = 0; m_irq = 0;
            m_start = 0; m_edge = 0; m_s = 0; m_tag = 0; m_result = 0;
        end else begin
            rise = m_s[1] && !m_edge;
            req  = (bus_wr && bus_addr == 0) || (m_opt[7] && rise) || (m_opt[0] && pacer_tc);
            go   = req && !m_busy;
            fin  = m_busy && adc_done;
            if (bus_rd && bus_addr == 4) m_irq = 0;
            if (fin) begin
                m_result = {m_tag, adc_data};
                m_busy = 0;
                if (m_opt[2]) m_irq = 1;
            end
            if (go) begin m_busy = 1; m_tag = m_sub[7:4]; end
            m_start = go;
            m_edge = m_s[1]; m_s[1] = m_s[0]; m_s[0] = ext_start_pin;
            if (bus_wr && bus_addr == 2) m_ctrl = bus_wdata;
            if (bus_wr && bus_addr == 3) m_sub = {bus_wdata[7:4], 1'b0, bus_wdata[2:0]};
            if (bus_wr && bus_addr == 4) m_opt = bus_wdata;
        end
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model.
    always @(negedge clk) begin
        if (rst_n) begin
            if (adc_start) start_cnt++;
            chk("R5 start", adc_start, m_start);
            chk("R11 irq", irq, m_irq);
            chk("R3 chan", adc_chan, m_ctrl[3] ? {1'b0, m_ctrl[6:4]} : m_ctrl[7:4]);
            chk("R2 diff/range", {adc_diff, adc_range}, m_ctrl[3:0]);
            chk("R4 submux", {submux_sel, submux_gain}, {m_sub[7:4], m_sub[2:0]});
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1; bus_addr = a; #1 d = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic finish_conv(input logic [11:0] d);
        repeat (2) @(negedge clk);
        adc_done = 1; adc_data = d;
        @(negedge clk); adc_done = 0;
    endtask

    task automatic pulse_tc;
        @(negedge clk); pacer_tc = 1;
        @(negedge clk); pacer_tc = 0;
    endtask

    logic [7:0] v;
    int base;

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd(4, v); chk("R1 status", v, 8'h80);
        rd(2, v); chk("R1 ctrl", v, 0);
        rd(3, v); chk("R1 submux", v, 0);
        rd(0, v); chk("R1 result", v, 0);
        chk("R1 irq", irq, 0);
        chk("R1 start", adc_start, 0);
        // R2 control byte
        wr(2, 8'h5B); rd(2, v); chk("R2 readback", v, 8'h5B);
        chk("R2 range", adc_range, 3); chk("R2 diff", adc_diff, 1);
        // R3 differential masking
        wr(2, 8'hF8); rd(2, v); chk("R3 readback", v, 8'hF8);
        chk("R3 chan diff", adc_chan, 4'd7);
        wr(2, 8'hE4); chk("R3 chan se", adc_chan, 4'd14);
        // R4 submux byte
        wr(3, 8'hAF); rd(3, v); chk("R4 readback", v, 8'hA7);
        chk("R4 sel", submux_sel, 4'hA); chk("R4 gain", submux_gain, 3'd7);
        // R5/R6/R7/R11 software conversion with interrupt
        wr(4, 8'h04);
        base = start_cnt;
        wr(0, 8'h3C);
        @(negedge clk); chk("R5 one start", start_cnt - base, 1);
        rd(4, v); chk("R6 busy status", v, 8'h00);
        wr(3, 8'h50);
        finish_conv(12'h9C3);
        chk("R11 irq raised", irq, 1);
        rd(1, v); chk("R7 high byte tag", v, 8'hA9);
        rd(0, v); chk("R7 low byte", v, 8'hC3);
        rd(4, v); chk("R6 idle status", v, 8'h80);
        @(negedge clk); chk("R11 irq cleared", irq, 0);
        // R12 requests while busy
        wr(4, 8'h05);
        base = start_cnt;
        wr(0, 8'h00);
        wr(0, 8'hFF); pulse_tc;
        finish_conv(12'h001);
        @(negedge clk); chk("R12 ignored while busy", start_cnt - base, 1);
        rd(4, v);
        // R10 pacer gating
        wr(4, 8'h01);
        base = start_cnt; pulse_tc;
        @(negedge clk); chk("R10 tc start", start_cnt - base, 1);
        finish_conv(12'h123);
        wr(4, 8'h00);
        base = start_cnt; pulse_tc; repeat (3) @(negedge clk);
        chk("R10 tc disabled", start_cnt - base, 0);
        // R8 pin level in status, no start
        base = start_cnt;
        @(negedge clk); ext_start_pin = 1;
        repeat (2) @(negedge clk);
        rd(4, v); chk("R8 pin level", v, 8'h81);
        chk("R8 no start", start_cnt - base, 0);
        @(negedge clk); ext_start_pin = 0;
        repeat (4) @(negedge clk);
        // R9 external edge start
        wr(4, 8'h80);
        base = start_cnt;
        @(negedge clk); ext_start_pin = 1;
        repeat (4) @(negedge clk);
        chk("R9 edge start", start_cnt - base, 1);
        finish_conv(12'hABC);
        repeat (6) @(negedge clk);
        chk("R9 level no restart", start_cnt - base, 1);
        ext_start_pin = 0; repeat (4) @(negedge clk);
        // R13 other option bits
        wr(4, 8'h7A);
        base = start_cnt;
        pulse_tc;
        @(negedge clk); ext_start_pin = 1; repeat (5) @(negedge clk); ext_start_pin = 0;
        repeat (3) @(negedge clk);
        chk("R13 no start", start_cnt - base, 0);
        wr(0, 8'h11); finish_conv(12'h777);
        @(negedge clk); chk("R13 no irq", irq, 0);
        rd(0, v); chk("R7 result low", v, 8'h77);
        repeat (3) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule